// File: doc/BRIEF.md
# Transmit Character Queue with Early-Full Flagging

This block is a synchronous first-in first-out queue that sits between a host parallel write port and the read side of a transmit encoder. Every slot holds one character together with three side bits. The side bits are a start-of-cell marker, a special-versus-data select and a violation-send request. A single clock drives both sides. A synchronous clear input throws away everything stored.

The queue drives three occupancy flags:

- **Empty:** asserted while nothing is held.
- **Half:** an active-low indication that half the slots are in use.
- **Full (early):** asserted while there is still a margin of free slots. A host that reacts a few cycles late therefore loses nothing.

A timing-mode input sets the active level of the write enable, the empty flag and the full flag. Two styles are supported: a cell-bus style where these are active low, and a cascade style where they are active high. The half flag is active low in both modes.

The encoder pulls characters with an active-high read request. The slot appears on the read outputs one clock later, together with a valid strobe.

Top module: `tx_char_fifo`

## Requirements
- R1: While `clr` is high at a clock edge, the queue is emptied by that edge. After the edge, empty is active, half is inactive (`half_n`=1), full is inactive and `rd_valid`=0. Slots held before the clear are never read out.
- R2: Slots leave in the order they were written. Each slot is the 10-bit character plus start-of-cell, special select and violation bits. A read request accepted at an edge puts that slot on the read outputs with `rd_valid`=1 after that same edge.
- R3: The empty flag is active exactly while occupancy is zero. In cascade mode (`cascade_mode`=1) active means 1; in cell-bus mode (`cascade_mode`=0) active means 0.
- R4: `half_n` is 0 while occupancy is at least DEPTH/2 (128 by default), and 1 otherwise.
- R5: The full flag is active while occupancy is at least DEPTH-8 (248 by default), and inactive below that. Its active level follows the same mode rule as R3.
- R6: Once the full flag first goes active, at least 8 further writes are stored, and each is later read back intact.
- R7: A write attempted while all DEPTH slots are occupied is dropped. The stored contents and the occupancy do not change.
- R8: A read request while the queue is empty gives `rd_valid`=0 on the next cycle and does not change occupancy.
- R9: The write enable `wr_en` is active high in cascade mode and active low in cell-bus mode. An inactive level stores nothing.
- R10: A write and a read in the same cycle, with occupancy between 1 and DEPTH-1, leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| clr | input | 1 | Synchronous clear, active high |
| cascade_mode | input | 1 | 1 = cascade polarity, 0 = cell-bus polarity |
| wr_en | input | 1 | Write enable, polarity set by mode |
| wr_char | input | 10 | Character to store |
| wr_soc | input | 1 | Start-of-cell side bit |
| wr_spc | input | 1 | Special/data select side bit |
| wr_viol | input | 1 | Violation-send side bit |
| rd_req | input | 1 | Read request from encoder, active high |
| rd_char | output | 10 | Character read out |
| rd_soc | output | 1 | Start-of-cell bit read out |
| rd_spc | output | 1 | Special select bit read out |
| rd_viol | output | 1 | Violation bit read out |
| rd_valid | output | 1 | Read outputs carry a slot this cycle |
| empty_flag | output | 1 | Empty indication, polarity set by mode |
| half_n | output | 1 | Half-occupied indication, active low |
| full_flag | output | 1 | Early full indication, polarity set by mode |

## Verification
The assertions take `cascade_mode` to be held steady except while `clr` is high. They decode the empty and full levels from the mode, so a mode change in mid-stream would make them misread the flags. The bench changes the mode only inside a clear. It drives every input half a period away from the active edge, so each request is seen at exactly one edge. The occupancy limits are approached with counted write bursts, which land the flags on the exact thresholds 127/128, 247/248 and 256.

// File: rtl/txq_pkg.sv
package txq_pkg;
   localparam int CHAR_W = 10;

   typedef struct packed {
      logic              viol;
      logic              spc;
      logic              soc;
      logic [CHAR_W-1:0] chr;
   } txq_slot_t;

   localparam int SLOT_W = $bits(txq_slot_t);
endpackage

// File: rtl/txq_store.sv
module txq_store
   import txq_pkg::*;
#(
   parameter int DEPTH = 256,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  txq_slot_t       wdata,
   input  logic            re,
   input  logic [AW-1:0]   raddr,
   output txq_slot_t       rdata
);
   txq_slot_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs #(
   parameter int DEPTH = 256,
   localparam int AW = $clog2(DEPTH),
   localparam int OW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          wr_act,
   input  logic          rd_req,
   output logic          we,
   output logic          re,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [OW-1:0] occ
);
   localparam logic [OW-1:0] OCC_MAX = OW'(DEPTH);
   localparam bit POW2 = (DEPTH == (1 << AW));

   logic [AW-1:0] wnext, rnext;

   assign we = wr_act && (occ != OCC_MAX);
   assign re = rd_req && (occ != '0);

   generate
      if (POW2) begin : g_wrap_free
         assign wnext = waddr + 1'b1;
         assign rnext = raddr + 1'b1;
      end else begin : g_wrap_cmp
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         assign wnext = (waddr == LAST) ? '0 : waddr + 1'b1;
         assign rnext = (raddr == LAST) ? '0 : raddr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) begin
         waddr <= '0;
         raddr <= '0;
         occ   <= '0;
      end else begin
         if (we) waddr <= wnext;
         if (re) raddr <= rnext;
         case ({we, re})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
   parameter int DEPTH = 256,
   parameter int FULL_MARGIN = 8,
   localparam int OW = $clog2(DEPTH + 1)
) (
   input  logic          cascade_mode,
   input  logic [OW-1:0] occ,
   output logic          empty_flag,
   output logic          half_n,
   output logic          full_flag
);
   localparam logic [OW-1:0] HALF_LVL = OW'(DEPTH / 2);
   localparam logic [OW-1:0] FULL_LVL = OW'(DEPTH - FULL_MARGIN);

   logic is_empty, is_full;

   assign is_empty = (occ == '0);
   assign is_full  = (occ >= FULL_LVL);
   assign half_n   = !(occ >= HALF_LVL);

   // cascade style: active high; cell-bus style: active low
   assign empty_flag = cascade_mode ? is_empty : !is_empty;
   assign full_flag  = cascade_mode ? is_full  : !is_full;
endmodule

// File: rtl/tx_char_fifo.sv
module tx_char_fifo
   import txq_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int FULL_MARGIN = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int OW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              cascade_mode,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_char,
   input  logic              wr_soc,
   input  logic              wr_spc,
   input  logic              wr_viol,
   input  logic              rd_req,
   output logic [CHAR_W-1:0] rd_char,
   output logic              rd_soc,
   output logic              rd_spc,
   output logic              rd_viol,
   output logic              rd_valid,
   output logic              empty_flag,
   output logic              half_n,
   output logic              full_flag
);
   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("tx_char_fifo: DEPTH must be at least 4");
      end
      if (FULL_MARGIN < 1 || 2 * FULL_MARGIN > DEPTH) begin : g_bad_margin
         $error("tx_char_fifo: FULL_MARGIN must lie in 1..DEPTH/2");
      end
   endgenerate

   logic          wr_act, we, re;
   logic [AW-1:0] waddr, raddr;
   logic [OW-1:0] occ;
   txq_slot_t     wslot, rslot;

   assign wr_act = cascade_mode ? wr_en : !wr_en;
   assign wslot  = '{viol: wr_viol, spc: wr_spc, soc: wr_soc, chr: wr_char};

   txq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .clr    (clr),
      .wr_act (wr_act),
      .rd_req (rd_req),
      .we     (we),
      .re     (re),
      .waddr  (waddr),
      .raddr  (raddr),
      .occ    (occ)
   );

   txq_store #(.DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wslot),
      .re    (re),
      .raddr (raddr),
      .rdata (rslot)
   );

   txq_flags #(.DEPTH(DEPTH), .FULL_MARGIN(FULL_MARGIN)) u_flags (
      .cascade_mode (cascade_mode),
      .occ          (occ),
      .empty_flag   (empty_flag),
      .half_n       (half_n),
      .full_flag    (full_flag)
   );

   always_ff @(posedge clk) begin
      if (clr) rd_valid <= 1'b0;
      else     rd_valid <= re;
   end

   assign rd_char = rslot.chr;
   assign rd_soc  = rslot.soc;
   assign rd_spc  = rslot.spc;
   assign rd_viol = rslot.viol;
endmodule

// File: rtl/tx_char_fifo_chk.sv
module tx_char_fifo_chk #(
   parameter int DEPTH = 256,
   parameter int FULL_MARGIN = 8,
   localparam int OW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          clr,
   input logic          cascade_mode,
   input logic          wr_act,
   input logic          rd_req,
   input logic          rd_valid,
   input logic          empty_flag,
   input logic          half_n,
   input logic          full_flag,
   input logic [OW-1:0] occ
);
   localparam logic [OW-1:0] OCC_MAX = OW'(DEPTH);

   logic empty_on, full_on;
   assign empty_on = cascade_mode ? empty_flag : !empty_flag;
   assign full_on  = cascade_mode ? full_flag  : !full_flag;

   // R1
   clear_state_chk: assert property (@(posedge clk)
      clr |=> (occ == '0) && !rd_valid);

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (clr)
      occ <= OCC_MAX);

   // R7
   drop_when_full_chk: assert property (@(posedge clk) disable iff (clr)
      (occ == OCC_MAX) && wr_act && !rd_req |=> $stable(occ));

   // R8
   read_empty_chk: assert property (@(posedge clk) disable iff (clr)
      rd_req && empty_on |=> !rd_valid && (occ == '0));

   // R2
   read_valid_chk: assert property (@(posedge clk) disable iff (clr)
      rd_req && !empty_on |=> rd_valid);

   // R3
   empty_excl_chk: assert property (@(posedge clk) disable iff (clr)
      empty_on |-> !full_on && half_n);

   // R10
   occ_hold_chk: assert property (@(posedge clk) disable iff (clr)
      wr_act && rd_req && (occ != '0) && (occ != OCC_MAX) |=> $stable(occ));
endmodule

bind tx_char_fifo tx_char_fifo_chk #(.DEPTH(DEPTH), .FULL_MARGIN(FULL_MARGIN)) u_chk (
   .clk          (clk),
   .clr          (clr),
   .cascade_mode (cascade_mode),
   .wr_act       (wr_act),
   .rd_req       (rd_req),
   .rd_valid     (rd_valid),
   .empty_flag   (empty_flag),
   .half_n       (half_n),
   .full_flag    (full_flag),
   .occ          (occ)
);

// File: tb/tb_tx_char_fifo.sv
module tb_tx_char_fifo;
   localparam int DEPTH = 256;
   localparam int NVEC  = 10;

   logic clk = 1'b0;
   logic clr, cascade_mode, wr_en, rd_req;
   logic [9:0] wr_char;
   logic wr_soc, wr_spc, wr_viol;
   logic [9:0] rd_char;
   logic rd_soc, rd_spc, rd_viol, rd_valid, empty_flag, half_n, full_flag;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   tx_char_fifo dut (
      .clk(clk), .clr(clr), .cascade_mode(cascade_mode), .wr_en(wr_en),
      .wr_char(wr_char), .wr_soc(wr_soc), .wr_spc(wr_spc), .wr_viol(wr_viol),
      .rd_req(rd_req), .rd_char(rd_char), .rd_soc(rd_soc), .rd_spc(rd_spc),
      .rd_viol(rd_viol), .rd_valid(rd_valid), .empty_flag(empty_flag),
      .half_n(half_n), .full_flag(full_flag)
   );

   // vector: {op[1:0], wdata[12:0], exp_valid, exp_data[12:0], exp_empty}
   // op: 0 idle, 1 write, 2 read, 3 write+read; cascade mode
   localparam logic [29:0] VEC [NVEC] = '{
      {2'd1, 13'h0155, 1'b0, 13'h0000, 1'b0},
      {2'd1, 13'h1A3C, 1'b0, 13'h0000, 1'b0},
      {2'd2, 13'h0000, 1'b1, 13'h0155, 1'b0},
      {2'd3, 13'h0F0F, 1'b1, 13'h1A3C, 1'b0},
      {2'd2, 13'h0000, 1'b1, 13'h0F0F, 1'b1},
      {2'd2, 13'h0000, 1'b0, 13'h0000, 1'b1},
      {2'd1, 13'h1FFF, 1'b0, 13'h0000, 1'b0},
      {2'd3, 13'h0000, 1'b1, 13'h1FFF, 1'b0},
      {2'd2, 13'h0000, 1'b1, 13'h0000, 1'b1},
      {2'd0, 13'h0000, 1'b0, 13'h0000, 1'b1}
   };

   function automatic logic [12:0] pat(input int i);
      return 13'((i * 37 + 5) ^ (i << 9));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [12:0] rd_word();
      return {rd_viol, rd_spc, rd_soc, rd_char};
   endfunction

   // one cycle: drive after a falling edge, return at the next falling edge
   task automatic cyc(input logic w, input logic r, input logic [12:0] d);
      wr_en = cascade_mode ? w : !w;
      rd_req = r;
      {wr_viol, wr_spc, wr_soc, wr_char} = d;
      @(negedge clk);
      wr_en = cascade_mode ? 1'b0 : 1'b1;
      rd_req = 1'b0;
   endtask

   task automatic do_clear(input logic mode);
      clr = 1'b1;
      cascade_mode = mode;
      wr_en = mode ? 1'b0 : 1'b1;
      rd_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      clr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      clr = 1'b1; cascade_mode = 1'b1; wr_en = 1'b0; rd_req = 1'b0;
      {wr_viol, wr_spc, wr_soc, wr_char} = '0;
      @(negedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 empty", 32'(empty_flag), 32'd1);
      chk("R1 half_n", 32'(half_n), 32'd1);
      chk("R1 full", 32'(full_flag), 32'd0);
      chk("R1 rd_valid", 32'(rd_valid), 32'd0);
      clr = 1'b0;

      // R2 R3 R8 R10 table walk
      for (int k = 0; k < NVEC; k++) begin
         logic [29:0] v;
         v = VEC[k];
         cyc(v[28], v[29], v[27:15]);
         chk($sformatf("R2 valid vec%0d", k), 32'(rd_valid), 32'(v[14]));
         if (v[14]) chk($sformatf("R2 data vec%0d", k), 32'(rd_word()), 32'(v[13:1]));
         chk($sformatf("R3 empty vec%0d", k), 32'(empty_flag), 32'(v[0]));
      end

      // R9 cell-bus mode: high enable stores nothing, low enable stores
      do_clear(1'b0);
      chk("R3 empty low in cell-bus mode", 32'(empty_flag), 32'd0);
      wr_en = 1'b1; {wr_viol, wr_spc, wr_soc, wr_char} = 13'h0AAA;
      @(negedge clk);
      chk("R9 inactive enable ignored", 32'(empty_flag), 32'd0);
      cyc(1'b1, 1'b0, 13'h1234);
      chk("R9 active-low enable stores", 32'(empty_flag), 32'd1);
      cyc(1'b0, 1'b1, 13'h0);
      chk("R9 stored word", 32'(rd_word()), 32'h1234);

      // R5 polarity in cell-bus mode, then R1 clear drops content
      for (int i = 0; i < 248; i++) cyc(1'b1, 1'b0, pat(i));
      chk("R5 full active low", 32'(full_flag), 32'd0);
      do_clear(1'b0);
      chk("R1 clear empties", 32'(empty_flag), 32'd0);
      cyc(1'b0, 1'b1, 13'h0);
      chk("R1 nothing after clear", 32'(rd_valid), 32'd0);

      // R9 cascade: low enable stores nothing
      do_clear(1'b1);
      wr_en = 1'b0; @(negedge clk);
      chk("R9 cascade low enable ignored", 32'(empty_flag), 32'd1);

      // R4 R5 R6 R7 fill to the top in cascade mode
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1'b1, 1'b0, pat(i));
         if (i == 126) chk("R4 half at 127", 32'(half_n), 32'd1);
         if (i == 127) chk("R4 half at 128", 32'(half_n), 32'd0);
         if (i == 246) chk("R5 full at 247", 32'(full_flag), 32'd0);
         if (i == 247) chk("R5 full at 248", 32'(full_flag), 32'd1);
      end
      cyc(1'b1, 1'b0, 13'h1ABC);   // R7 dropped write
      for (int i = 0; i < DEPTH; i++) begin
         cyc(1'b0, 1'b1, 13'h0);
         if (rd_word() !== pat(i) || !rd_valid) begin
            chk($sformatf("R6 R7 slot %0d", i), 32'(rd_word()), 32'(pat(i)));
         end
         if (i == 7) chk("R5 full off at 248", 32'(full_flag), 32'd1);
         if (i == 8) chk("R5 full off at 247", 32'(full_flag), 32'd0);
      end
      chk("R6 all margin slots read", 32'(empty_flag), 32'd1);
      cyc(1'b0, 1'b1, 13'h0);
      chk("R7 extra write was dropped", 32'(rd_valid), 32'd0);

      // R10 simultaneous traffic at exactly half
      do_clear(1'b1);
      for (int i = 0; i < 128; i++) cyc(1'b1, 1'b0, pat(i));
      for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 13'h0);
      chk("R10 occupancy held at 128", 32'(half_n), 32'd0);
      cyc(1'b0, 1'b1, 13'h0);
      chk("R10 one read drops to 127", 32'(half_n), 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule